// File: doc/BRIEF.md
# MDIO Clause 22 Management Master

This block runs one Clause 22 management frame at a time toward an Ethernet PHY. A one-cycle start request, together with a read/write select, a 5-bit PHY address, a 5-bit register address, 16 bits of write data and a 3-bit clock-divider selection, is captured while the block is idle. The block then generates the management clock (MDC) from the system clock and shifts the frame out on the data line (MDO, with its output enable). In a read frame it samples the PHY's answer on MDI.

During a frame a busy flag is high. Requests that arrive while busy is high are dropped. When a read frame completes, the 16 sampled bits are held on a read-data output until the next read frame replaces them. A separate register block is expected to supply the request fields and consume busy and the read data.

Top module: `mdio_mgmt_master`

## Requirements
- R1: A frame is 64 MDC periods long and is sent most significant bit first, in this order: 32 ones of preamble, start bits 0 then 1, a 2-bit opcode, the PHY address, the register address, 2 turnaround bits, then 16 data bits.
- R2: The opcode is 0 then 1 for a write and 1 then 0 for a read. In a write frame the turnaround bits are 1 then 0 and the data field carries the write data.
- R3: In a read frame, mdo_en is high for the first 46 bit periods (preamble through register address). It is low for both turnaround bits and all 16 data bits. In a write frame, mdo_en is high for all 64 bit periods.
- R4: The clock-divider selection maps to a divisor N of the system clock as follows: 0 and 1 give 4, 2 gives 6, 3 gives 8, 4 gives 10, 5 gives 14, 6 gives 20 and 7 gives 28. During a frame, MDC is low for N/2 cycles and then high for N/2 cycles in every period.
- R5: MDO changes only on the cycle in which MDC falls, with one exception: the first preamble bit appears when the request is accepted, while MDC is still low. MDI is sampled on the cycle in which MDC rises.
- R6: Busy goes high on the clock edge that accepts a start request and stays high for exactly 64*N system clock cycles. It drops on the same edge as the final MDC fall.
- R7: A start request made while busy is high has no effect on the frame in progress, and no second frame follows it.
- R8: The request fields and the divider selection are captured at acceptance. Changes to these inputs during a frame do not alter that frame.
- R9: After a read frame, rd_data holds the 16 bits sampled from MDI, the first sampled bit in bit 15. A write frame leaves rd_data unchanged.
- R10: Out of reset and between frames, busy, mdc, mdo and mdo_en are all low, and rd_data resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_start | input | 1 | One-cycle request to run a frame |
| cmd_read | input | 1 | 1 selects a read frame, 0 a write frame |
| phy_addr | input | 5 | Target PHY address |
| reg_addr | input | 5 | Target register address |
| wr_data | input | 16 | Data for a write frame |
| clk_div_sel | input | 3 | MDC divisor selection |
| mdi | input | 1 | Management data from the PHY |
| mdc | output | 1 | Management clock |
| mdo | output | 1 | Management data toward the PHY |
| mdo_en | output | 1 | Output enable for mdo |
| rd_data | output | 16 | Data from the last read frame |
| busy | output | 1 | High while a frame is in progress |

## Verification
The hardest cases to reach are a request that lands in the middle of a frame and the turnaround of a read frame, where the PHY must take over the line exactly as mdo_en drops. The bench contains a PHY model that watches MDC. It records mdo and mdo_en at every rising edge, and after each falling edge it drives the next answer bit, with a 0 in the second turnaround bit. To exercise the mid-frame case, selected frames inject a second request part-way through, with the read/write select, addresses and divider selection all changed. The bench then confirms that the recorded bits, the MDC phase lengths and the busy length all belong to the original request, and that busy stays low afterwards.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

    localparam int SEL_W   = 3;
    localparam int MAX_DIV = 28;

    // Divisor of the system clock for each MDC selection code
    function automatic int unsigned div_of(input logic [SEL_W-1:0] sel);
        case (sel)
            3'd0, 3'd1: div_of = 4;
            3'd2:       div_of = 6;
            3'd3:       div_of = 8;
            3'd4:       div_of = 10;
            3'd5:       div_of = 14;
            3'd6:       div_of = 20;
            default:    div_of = 28;
        endcase
    endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen
    import mdio_mgmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             mdc_o,
    output logic             rise_o,
    output logic             fall_o
);
    localparam int CNT_W = $clog2(MAX_DIV);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             mdc;
    } gen_t;

    gen_t gen_d, gen_q;
    logic [CNT_W-1:0] half_cnt, last_cnt;

    always_comb begin
        half_cnt = CNT_W'(div_of(sel_i) / 2 - 1);
        last_cnt = CNT_W'(div_of(sel_i) - 1);
        rise_o   = en_i && (gen_q.cnt == half_cnt);
        fall_o   = en_i && (gen_q.cnt == last_cnt);
        gen_d    = gen_q;
        if (!en_i) begin
            gen_d = '0;
        end else if (fall_o) begin
            gen_d.cnt = '0;
            gen_d.mdc = 1'b0;
        end else begin
            gen_d.cnt = gen_q.cnt + 1'b1;
            if (rise_o) gen_d.mdc = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gen_q <= '0;
        else        gen_q <= gen_d;
    end

    assign mdc_o = gen_q.mdc;

    // R4
    edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_o && fall_o));
    // R4
    rise_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> mdc_o);
    // R5
    fall_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !mdc_o);
    // R10
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !mdc_o);

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_mgmt_pkg::*;
#(
    parameter int PRE_LEN = 32,
    parameter int PHY_W   = 5,
    parameter int REG_W   = 5,
    parameter int DATA_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              rd_i,
    input  logic [PHY_W-1:0]  phy_i,
    input  logic [REG_W-1:0]  reg_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic              mdi_i,
    output logic              busy_o,
    output logic [SEL_W-1:0]  sel_o,
    output logic              mdo_o,
    output logic              mdo_en_o,
    output logic [DATA_W-1:0] rd_data_o
);
    localparam int FRAME_W  = PRE_LEN + 4 + PHY_W + REG_W + 2 + DATA_W;
    localparam int TA_POS   = PRE_LEN + 4 + PHY_W + REG_W;
    localparam int DATA_POS = TA_POS + 2;
    localparam int IDX_W    = $clog2(FRAME_W);
    localparam logic [IDX_W-1:0] TA_I   = IDX_W'(TA_POS);
    localparam logic [IDX_W-1:0] DATA_I = IDX_W'(DATA_POS);
    localparam logic [IDX_W-1:0] LAST_I = IDX_W'(FRAME_W - 1);

    typedef struct packed {
        logic               busy;
        logic               rd;
        logic [SEL_W-1:0]   sel;
        logic [IDX_W-1:0]   idx;
        logic [FRAME_W-1:0] sh;
        logic               oe;
        logic               mdo;
        logic [DATA_W-1:0]  rdata;
    } seq_t;

    seq_t seq_d, seq_q;
    logic [FRAME_W-1:0] frame_w;
    logic [IDX_W-1:0]   idx_nxt;

    always_comb begin
        frame_w = {{PRE_LEN{1'b1}}, 2'b01,
                   (rd_i ? 2'b10 : 2'b01),
                   phy_i, reg_i,
                   (rd_i ? 2'b00 : 2'b10),
                   (rd_i ? {DATA_W{1'b0}} : wdata_i)};
        idx_nxt = seq_q.idx + 1'b1;
        seq_d   = seq_q;
        if (!seq_q.busy) begin
            if (start_i) begin
                seq_d.busy = 1'b1;
                seq_d.rd   = rd_i;
                seq_d.sel  = sel_i;
                seq_d.idx  = '0;
                seq_d.sh   = frame_w;
                seq_d.oe   = 1'b1;
                seq_d.mdo  = frame_w[FRAME_W-1];
            end
        end else begin
            if (rise_i && seq_q.rd && (seq_q.idx >= DATA_I))
                seq_d.rdata = {seq_q.rdata[DATA_W-2:0], mdi_i};
            if (fall_i) begin
                if (seq_q.idx == LAST_I) begin
                    seq_d.busy = 1'b0;
                    seq_d.oe   = 1'b0;
                    seq_d.mdo  = 1'b0;
                end else begin
                    seq_d.idx = idx_nxt;
                    seq_d.sh  = seq_q.sh << 1;
                    seq_d.oe  = !(seq_q.rd && (idx_nxt >= TA_I));
                    seq_d.mdo = seq_d.oe & seq_q.sh[FRAME_W-2];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign busy_o    = seq_q.busy;
    assign sel_o     = seq_q.sel;
    assign mdo_o     = seq_q.mdo;
    assign mdo_en_o  = seq_q.oe;
    assign rd_data_o = seq_q.rdata;

    // R7
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.busy && start_i) |=> ($stable(seq_q.rd) && $stable(seq_q.sel)));
    // R3
    rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.busy && seq_q.rd && seq_q.idx >= TA_I) |-> !mdo_en_o);
    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!mdo_en_o && !mdo_o));
    // R9
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> $stable(rd_data_o));
    // R5
    bit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !fall_i) |=> ($stable(seq_q.idx) && $stable(mdo_o)));

endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
    import mdio_mgmt_pkg::*;
#(
    parameter int PRE_LEN = 32,
    parameter int PHY_W   = 5,
    parameter int REG_W   = 5,
    parameter int DATA_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic              cmd_read,
    input  logic [PHY_W-1:0]  phy_addr,
    input  logic [REG_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [SEL_W-1:0]  clk_div_sel,
    input  logic              mdi,
    output logic              mdc,
    output logic              mdo,
    output logic              mdo_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy
);
    logic             rise_w, fall_w;
    logic [SEL_W-1:0] sel_w;

    mdio_mdc_gen u_gen (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (busy),
        .sel_i  (sel_w),
        .mdc_o  (mdc),
        .rise_o (rise_w),
        .fall_o (fall_w)
    );

    mdio_frame_seq #(
        .PRE_LEN (PRE_LEN),
        .PHY_W   (PHY_W),
        .REG_W   (REG_W),
        .DATA_W  (DATA_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (cmd_start),
        .rd_i      (cmd_read),
        .phy_i     (phy_addr),
        .reg_i     (reg_addr),
        .wdata_i   (wr_data),
        .sel_i     (clk_div_sel),
        .rise_i    (rise_w),
        .fall_i    (fall_w),
        .mdi_i     (mdi),
        .busy_o    (busy),
        .sel_o     (sel_w),
        .mdo_o     (mdo),
        .mdo_en_o  (mdo_en),
        .rd_data_o (rd_data)
    );

    // R10
    mdc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> !mdc);

endmodule

// File: tb/mdio_mgmt_master_tb.sv
module mdio_mgmt_master_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_start = 1'b0, cmd_read = 1'b0;
    logic [4:0]  phy_addr = '0, reg_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  clk_div_sel = '0;
    logic        mdi = 1'b1;
    logic        mdc, mdo, mdo_en, busy;
    logic [15:0] rd_data;

    always #5 clk = ~clk;

    mdio_mgmt_master dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_read(cmd_read),
        .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data),
        .clk_div_sel(clk_div_sel), .mdi(mdi), .mdc(mdc), .mdo(mdo),
        .mdo_en(mdo_en), .rd_data(rd_data), .busy(busy)
    );

    int tests = 0, fails = 0;
    int cyc = 0;
    bit done = 0;

    // PHY model and monitor state
    logic [63:0] got_bits, got_oe;
    int          rise_cnt, run_len, run_min, run_max;
    bit          first_run, mdo_bad, prev_mdc, prev_mdo;
    logic [15:0] mon_pat;
    bit          mon_rd;
    int          idle_bad = 0;

    function automatic int div_n(input logic [2:0] s);
        int t[8] = '{4, 4, 6, 8, 10, 14, 20, 28};
        return t[s];
    endfunction

    function automatic logic [63:0] exp_frame(input bit rd, input logic [4:0] p,
                                              input logic [4:0] r, input logic [15:0] d);
        return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), p, r,
                (rd ? 2'b00 : 2'b10), (rd ? 16'h0 : d)};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (!busy && (mdc || mdo || mdo_en)) idle_bad++;
            if (mdo != prev_mdo && !(prev_mdc && !mdc) && rise_cnt > 0) mdo_bad = 1;
            if (mdc == prev_mdc) run_len++;
            else begin
                if (!first_run) begin
                    if (run_len < run_min) run_min = run_len;
                    if (run_len > run_max) run_max = run_len;
                end
                first_run = 0;
                run_len = 1;
            end
            if (mdc && !prev_mdc && rise_cnt < 64) begin
                got_bits[63-rise_cnt] = mdo;
                got_oe[63-rise_cnt]   = mdo_en;
                rise_cnt++;
            end
            if (!mdc && prev_mdc) begin
                if (mon_rd && rise_cnt == 47) mdi = 1'b0;
                else if (mon_rd && rise_cnt >= 48 && rise_cnt < 64) mdi = mon_pat[15-(rise_cnt-48)];
                else mdi = 1'b1;
            end
            prev_mdc = mdc;
            prev_mdo = mdo;
        end
    end

    logic [15:0] exp_rd = '0;

    task automatic run_frame(input bit rd, input logic [4:0] p, input logic [4:0] r,
                             input logic [15:0] d, input logic [2:0] s, input bit inject);
        int n, blen;
        logic [63:0] ef, em;
        n  = div_n(s);
        ef = exp_frame(rd, p, r, d);
        em = rd ? {46'h3FFF_FFFF_FFFF, 18'h0} : {64{1'b1}};
        @(negedge clk);
        cmd_read = rd; phy_addr = p; reg_addr = r; wr_data = d; clk_div_sel = s;
        mon_rd = rd; mon_pat = $urandom; mdi = 1'b1;
        rise_cnt = 0; first_run = 1; run_min = 1000; run_max = 0; mdo_bad = 0;
        got_bits = '0; got_oe = '0;
        cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        // R6: busy visible right after the accepting edge
        check(busy === 1'b1, "R6", "busy after start", busy, 1);
        blen = 1;
        forever begin
            @(negedge clk);
            if (!busy) break;
            blen++;
            if (inject && blen == 300) begin
                cmd_start = 1'b1; cmd_read = !rd; phy_addr = ~p; reg_addr = ~r;
                wr_data = ~d; clk_div_sel = s ^ 3'b111;
            end else if (inject && blen == 301) begin
                cmd_start = 1'b0;
            end else if (blen > 70*28) break;
        end
        // R8: inputs disturbed mid frame, frame must still match capture
        cmd_read = !rd; phy_addr = ~p; reg_addr = ~r; wr_data = ~d;
        repeat (2) @(negedge clk);
        check(blen == 64*n, "R6", "busy length", blen, 64*n);
        check(rise_cnt == 64 && got_bits == ef, "R1", "frame bits", got_bits, ef);
        check(got_oe == em, "R3", "enable pattern", got_oe, em);
        check(run_min == n/2 && run_max == n/2, "R4", "mdc phase", run_max*100+run_min, (n/2)*101);
        check(!mdo_bad, "R5", "mdo moved off mdc fall", mdo_bad, 0);
        if (rd) exp_rd = mon_pat;
        check(rd_data == exp_rd, "R9", "read data", rd_data, exp_rd);
        if (inject) begin
            repeat (20) @(negedge clk);
            check(!busy && rise_cnt == 64, "R7", "no second frame", busy, 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check(!busy && !mdc && !mdo && !mdo_en && rd_data == 0, "R10", "reset outputs",
              {busy, mdc, mdo, mdo_en, rd_data}, 0);
        rst_n = 1'b1;
        prev_mdc = 0; prev_mdo = 0; rise_cnt = 0;
        repeat (4) @(negedge clk);
        void'($urandom(32'h5EED_0D10));
        // directed corners: R2 write then read, both /4 codes, slowest code
        run_frame(0, 5'd31, 5'd0, 16'hFFFF, 3'd0, 0);
        run_frame(1, 5'd0, 5'd31, 16'h0000, 3'd1, 0);
        run_frame(0, 5'h15, 5'h0A, 16'h0000, 3'd7, 0);
        run_frame(1, 5'h0A, 5'h15, 16'h1234, 3'd7, 0);
        // R7 and R8: requests during a frame
        run_frame(0, 5'h03, 5'h11, 16'hA5C3, 3'd2, 1);
        run_frame(1, 5'h1C, 5'h02, 16'h0F0F, 3'd3, 1);
        for (int i = 0; i < 14; i++) begin
            run_frame(bit'($urandom & 1), 5'($urandom), 5'($urandom), 16'($urandom),
                      3'($urandom), bit'(($urandom % 4) == 0));
        end
        // R10: idle quiet between frames
        check(idle_bad == 0, "R10", "idle outputs", idle_bad, 0);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    always @(posedge clk) begin
        if (!done && cyc > 190000) begin
            done = 1;
            tests++; fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule